// File: doc/BRIEF.md
# External Bus Ready-Wait Controller

This block runs single read and write transfers from an internal master onto an external memory bus divided into four chip-select regions. The master presents an address, write data and a direction, and pulses a start strobe. The controller then drives the external address, data, chip-select and strobe lines. When the transfer ends, it returns a one-cycle done pulse and, for reads, the captured data. The two most significant address bits select the region.

Each region has one wait-enable bit in `wait_cfg`. When a region's bit is 1, the region is a fast region: its strobe lasts one clock and the external ready line has no effect. When the bit is 0, the region is a slow region: the strobe is followed by one fixed software wait cycle, and after that the controller samples the external ready input. The ready input passes through a two-stage synchronizer clocked on the falling edge. A low synchronized ready value stretches the strobe, and all bus outputs hold their values for as long as the stretch lasts.

The `mux_mode` input chooses the bus mode. In the separate bus mode, address lines and data lines are distinct. In the multiplexed bus mode, the data lines carry the address during the address cycle and the ALE strobe marks it.

The state machine has five states:
- ST_IDLE: nothing is driven. A sampled start moves to ST_ADDR.
- ST_ADDR: the address cycle, one clock long. It always moves to ST_STROBE.
- ST_STROBE: RD or WR is asserted. It moves to ST_IDLE in a fast region and to ST_SWAIT in a slow region.
- ST_SWAIT: the software wait cycle. It always moves to ST_RWAIT.
- ST_RWAIT: the controller samples ready. It stays in ST_RWAIT while the synchronized ready is low and moves to ST_IDLE when it is high.

Top module: `ext_bus_wait_ctrl`

## Requirements
- R1: After reset and whenever no transfer is active, all chip-select lines are high. RD and WR are high, ALE is low and `req_done` is low.
- R2: Address bits [15:14] pick region i. From the address cycle to the end of the strobe, exactly `bus_cs_n[i]` is low.
- R3: Let the edge that samples `req_start` be edge 0. When `wait_cfg[i]` is 1, `req_done` rises after edge 2, and the level of `ext_ready` has no effect.
- R4: When `wait_cfg[i]` is 0, the strobe runs for one clock and then one software wait cycle. Ready is first used at edge 4, so a ready that is high gives `req_done` after edge 4. A ready level present only during the cycle just before the software wait is not accepted.
- R5: In the ready-sampling state, a synchronized ready of 0 extends the cycle (ready is active high). A change applied just after edge k is first used at edge k+2. `req_done` follows the first edge at which the synchronized ready is 1.
- R6: While the cycle is extended, the address, data out, output enable, chip selects, ALE, RD and WR all keep their values.
- R7: `req_done` is high for exactly one clock. On that same edge RD and the chip select go high, and read data from `bus_din` is captured onto `req_rdata`.
- R8: When `mux_mode` is 1, the address cycle drives ALE high and places the address on `bus_dout` with `bus_oe` high. When `mux_mode` is 0, ALE stays low.
- R9: In a write, WR is low during the strobe, `bus_dout` carries the write data and `bus_oe` is 1. RD stays high.
- R10: A `req_start` that arrives while a transfer is active is ignored. After the done pulse the bus stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Start pulse from the master, sampled in ST_IDLE |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Transfer address; its top two bits select the region |
| req_wdata | input | DW | Write data |
| req_rdata | output | DW | Captured read data |
| req_done | output | 1 | One-cycle completion pulse |
| wait_cfg | input | NCS | Per-region bit: 1 = fast region, 0 = slow region |
| mux_mode | input | 1 | 1 = multiplexed address/data bus |
| ext_ready | input | 1 | External ready, active high, asynchronous |
| bus_addr | output | AW | External address lines |
| bus_dout | output | DW | External data (or address) out |
| bus_din | input | DW | External data in |
| bus_oe | output | 1 | Data output enable |
| bus_ale | output | 1 | Address latch enable |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_cs_n | output | NCS | Chip selects, active low |

## Verification
The hardest case to reach is a ready level that lands exactly in the cycle before the software wait. Because of the falling-edge synchronizer, that level reaches the state machine two rising edges after it is applied. The stimulus therefore holds ready low before the start and raises it just after edge 1. The synchronized value is still low while ST_STROBE is active and already high in ST_RWAIT, so the transfer must complete after edge 4 and not before. Longer stretches raise ready after edge 5 or edge 10. During each stretch the bench compares every bus output against a snapshot taken in the first strobe cycle.

// File: rtl/ebr_pkg.sv
package ebr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_STROBE,
        ST_SWAIT,
        ST_RWAIT
    } ebr_state_e;
endpackage

// File: rtl/ebr_ready_sync.sv
module ebr_ready_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rdy_in,
    output logic rdy_sync
);
    logic [STAGES-1:0] shift_q;

    // Sampling on the falling edge; the chain gives the setup latency.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else begin
            shift_q <= {shift_q[STAGES-2:0], rdy_in};
        end
    end

    assign rdy_sync = shift_q[STAGES-1];
endmodule

// File: rtl/ebr_region_decode.sv
module ebr_region_decode #(
    parameter int NCS = 4,
    localparam int RW = $clog2(NCS)
) (
    input  logic [RW-1:0]  region,
    input  logic [NCS-1:0] wait_cfg,
    output logic [NCS-1:0] sel_oh,
    output logic           rdy_en
);
    for (genvar g = 0; g < NCS; g++) begin : g_sel
        assign sel_oh[g] = (region == RW'(g));
    end

    // A cleared configuration bit enables ready for that region.
    assign rdy_en = ~|(sel_oh & wait_cfg);
endmodule

// File: rtl/ext_bus_wait_ctrl.sv
module ext_bus_wait_ctrl #(
    parameter int AW       = 16,
    parameter int DW       = 16,
    parameter int NCS      = 4,
    parameter int SYNC_STG = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_start,
    input  logic           req_write,
    input  logic [AW-1:0]  req_addr,
    input  logic [DW-1:0]  req_wdata,
    output logic [DW-1:0]  req_rdata,
    output logic           req_done,
    input  logic [NCS-1:0] wait_cfg,
    input  logic           mux_mode,
    input  logic           ext_ready,
    output logic [AW-1:0]  bus_addr,
    output logic [DW-1:0]  bus_dout,
    input  logic [DW-1:0]  bus_din,
    output logic           bus_oe,
    output logic           bus_ale,
    output logic           bus_rd_n,
    output logic           bus_wr_n,
    output logic [NCS-1:0] bus_cs_n
);
    import ebr_pkg::*;

    localparam int RW = $clog2(NCS);

    ebr_state_e state_q, state_nx;

    logic [AW-1:0]  addr_q;
    logic [DW-1:0]  wdata_q;
    logic [DW-1:0]  rdata_q;
    logic           write_q;
    logic           mux_q;
    logic           rdy_en_q;
    logic [NCS-1:0] sel_q;
    logic           done_q;

    logic [NCS-1:0] sel_dec;
    logic           rdy_en_dec;
    logic           rdy_sync;
    logic           accept;
    logic           finish;

    ebr_ready_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .rdy_in   (ext_ready),
        .rdy_sync (rdy_sync)
    );

    ebr_region_decode #(.NCS(NCS)) u_dec (
        .region   (req_addr[AW-1 -: RW]),
        .wait_cfg (wait_cfg),
        .sel_oh   (sel_dec),
        .rdy_en   (rdy_en_dec)
    );

    assign accept = (state_q == ST_IDLE) && req_start;
    assign finish = ((state_q == ST_STROBE) && !rdy_en_q) ||
                    ((state_q == ST_RWAIT)  &&  rdy_sync);

    // Next-state decision
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_start) state_nx = ST_ADDR;
            ST_ADDR:   state_nx = ST_STROBE;
            ST_STROBE: state_nx = rdy_en_q ? ST_SWAIT : ST_IDLE;
            ST_SWAIT:  state_nx = ST_RWAIT;
            ST_RWAIT:  if (rdy_sync) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Request capture, completion pulse and read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            write_q  <= 1'b0;
            mux_q    <= 1'b0;
            rdy_en_q <= 1'b0;
            sel_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= finish;
            if (accept) begin
                addr_q   <= req_addr;
                wdata_q  <= req_wdata;
                write_q  <= req_write;
                mux_q    <= mux_mode;
                rdy_en_q <= rdy_en_dec;
                sel_q    <= sel_dec;
            end
            if (finish && !write_q) begin
                rdata_q <= bus_din;
            end
        end
    end

    // Bus outputs, decoded from the state and the captured request
    always_comb begin
        bus_addr = addr_q;
        bus_dout = wdata_q;
        bus_oe   = 1'b0;
        bus_ale  = 1'b0;
        bus_rd_n = 1'b1;
        bus_wr_n = 1'b1;
        bus_cs_n = '1;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_ADDR: begin
                bus_cs_n = ~sel_q;
                bus_ale  = mux_q;
                bus_oe   = mux_q | write_q;
                if (mux_q) begin
                    bus_dout = DW'(addr_q);
                end
            end
            ST_STROBE, ST_SWAIT, ST_RWAIT: begin
                bus_cs_n = ~sel_q;
                bus_oe   = write_q;
                bus_rd_n = write_q;
                bus_wr_n = ~write_q;
            end
            default: begin
            end
        endcase
    end

    assign req_done  = done_q;
    assign req_rdata = rdata_q;
endmodule

// File: rtl/ebr_bus_checker.sv
module ebr_bus_checker #(
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int NCS = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_done,
    input logic [AW-1:0]  bus_addr,
    input logic [DW-1:0]  bus_dout,
    input logic           bus_oe,
    input logic           bus_ale,
    input logic           bus_rd_n,
    input logic           bus_wr_n,
    input logic [NCS-1:0] bus_cs_n
);
    logic strobe;
    assign strobe = !bus_rd_n || !bus_wr_n;

    // R1: with no chip select active, no strobe and no ALE
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (&bus_cs_n) |-> (bus_rd_n && bus_wr_n && !bus_ale));

    // R2: at most one region selected
    a_r2_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bus_cs_n));

    // R3: a strobe opens only after an address cycle on the same chip select
    a_r3_addr_first: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !$past(strobe)) |-> (!(&bus_cs_n) && $stable(bus_cs_n)));

    // R6: all bus outputs frozen while the strobe is stretched
    a_r6_hold_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && $past(strobe)) |-> ($stable(bus_addr) && $stable(bus_dout) &&
        $stable(bus_oe) && $stable(bus_ale) && $stable(bus_cs_n) &&
        $stable(bus_rd_n) && $stable(bus_wr_n)));

    // R7: done is a single-cycle pulse
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done);

    // R7: strobes and selects released together with done
    a_r7_done_release: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |-> ((&bus_cs_n) && bus_rd_n && bus_wr_n));

    // R8: ALE never overlaps a strobe and comes with the address driven
    a_r8_ale_phase: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> (bus_rd_n && bus_wr_n && bus_oe));

    // R9: never read and write together
    a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));
endmodule

bind ext_bus_wait_ctrl ebr_bus_checker #(.AW(AW), .DW(DW), .NCS(NCS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_done (req_done),
    .bus_addr (bus_addr),
    .bus_dout (bus_dout),
    .bus_oe   (bus_oe),
    .bus_ale  (bus_ale),
    .bus_rd_n (bus_rd_n),
    .bus_wr_n (bus_wr_n),
    .bus_cs_n (bus_cs_n)
);

// File: tb/test_ext_bus_wait_ctrl.sv
`timescale 1ns/1ps
module test_ext_bus_wait_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_start = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] req_rdata;
    logic        req_done;
    logic [3:0]  wait_cfg = 4'b1111;
    logic        mux_mode = 1'b0;
    logic        ext_ready = 1'b1;
    logic [15:0] bus_addr;
    logic [15:0] bus_dout;
    logic [15:0] bus_din = '0;
    logic        bus_oe;
    logic        bus_ale;
    logic        bus_rd_n;
    logic        bus_wr_n;
    logic [3:0]  bus_cs_n;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    ext_bus_wait_ctrl i_ext_bus_wait_ctrl (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_rdata(req_rdata),
        .req_done(req_done), .wait_cfg(wait_cfg), .mux_mode(mux_mode),
        .ext_ready(ext_ready), .bus_addr(bus_addr), .bus_dout(bus_dout),
        .bus_din(bus_din), .bus_oe(bus_oe), .bus_ale(bus_ale),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_cs_n(bus_cs_n)
    );

    // {write, addr, wdata, din, wait_cfg, mux, done edge}
    localparam logic [57:0] VEC [8] = '{
        {1'b0, 16'h1234, 16'h0000, 16'hA5A5, 4'b1111, 1'b0, 4'd2},
        {1'b0, 16'h5678, 16'h0000, 16'h0F0F, 4'b0000, 1'b0, 4'd4},
        {1'b1, 16'h9ABC, 16'hBEEF, 16'h0000, 4'b0100, 1'b0, 4'd2},
        {1'b1, 16'hC001, 16'h1357, 16'h0000, 4'b0111, 1'b1, 4'd4},
        {1'b0, 16'hC0DE, 16'h0000, 16'h2468, 4'b1000, 1'b1, 4'd2},
        {1'b0, 16'h4321, 16'h0000, 16'h7777, 4'b1101, 1'b1, 4'd4},
        {1'b1, 16'h0042, 16'hCAFE, 16'h0000, 4'b1110, 1'b0, 4'd4},
        {1'b0, 16'h8001, 16'h0000, 16'hFACE, 4'b1011, 1'b0, 4'd4}
    };

    task automatic chk(input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic run(input logic wr, input logic [15:0] addr, input logic [15:0] wdata,
                       input logic [15:0] din, input logic [3:0] cfg, input logic mux,
                       input int raise_at, input int expd, input bit poke, input string tag);
        logic [3:0]  exp_cs;
        logic [39:0] snap;
        int d;
        int frz;
        ext_ready = (raise_at < 0);
        wait_cfg  = cfg;
        mux_mode  = mux;
        bus_din   = din;
        req_write = wr;
        req_addr  = addr;
        req_wdata = wdata;
        repeat (3) @(posedge clk);
        #1 req_start = 1'b1;
        @(posedge clk);
        #1 req_start = 1'b0;
        exp_cs = ~(4'b0001 << addr[15:14]);
        chk(bus_cs_n == exp_cs, "R2 chip select in address cycle", 32'(bus_cs_n), 32'(exp_cs));
        chk(bus_ale == mux, "R8 ALE in address cycle", 32'(bus_ale), 32'(mux));
        chk(bus_dout == (mux ? addr : wdata), "R8 data lines in address cycle",
            32'(bus_dout), 32'(mux ? addr : wdata));
        d = -1;
        frz = 0;
        snap = '0;
        for (int k = 1; k <= 40; k++) begin
            @(posedge clk);
            #1;
            if (k == raise_at) ext_ready = 1'b1;
            if (poke && k == 1) req_start = 1'b1;
            if (poke && k == 2) req_start = 1'b0;
            if (req_done) begin
                d = k;
                break;
            end
            if (k == 1) begin
                snap = {bus_addr, bus_dout, bus_cs_n, bus_oe, bus_ale, bus_rd_n, bus_wr_n};
                if (wr)
                    chk(!bus_wr_n && bus_rd_n && bus_oe && bus_dout == wdata,
                        "R9 write strobe", {bus_dout, 13'd0, bus_oe, bus_rd_n, bus_wr_n},
                        {wdata, 13'd0, 3'b110});
                else
                    chk(!bus_rd_n && bus_wr_n && !bus_oe, "R3 read strobe",
                        {29'd0, bus_oe, bus_rd_n, bus_wr_n}, 32'b001);
            end else if (snap != {bus_addr, bus_dout, bus_cs_n, bus_oe, bus_ale, bus_rd_n, bus_wr_n}) begin
                frz++;
            end
        end
        chk(d == expd, tag, 32'(d), 32'(expd));
        chk(frz == 0, "R6 outputs held during stretch", 32'(frz), 32'd0);
        chk(bus_cs_n == 4'hF && bus_rd_n && bus_wr_n, "R7 release with done",
            {27'd0, bus_cs_n, bus_rd_n}, {27'd0, 4'hF, 1'b1});
        if (!wr) chk(req_rdata == din, "R7 read data capture", 32'(req_rdata), 32'(din));
        @(posedge clk);
        #1;
        chk(!req_done, "R7 done single cycle", 32'(req_done), 32'd0);
        if (poke) begin
            for (int j = 0; j < 4; j++) begin
                @(posedge clk);
                #1;
                chk(bus_cs_n == 4'hF && !req_done, "R10 start ignored while busy",
                    {27'd0, bus_cs_n, req_done}, {27'd0, 4'hF, 1'b0});
            end
        end
        ext_ready = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk(bus_cs_n == 4'hF && bus_rd_n && bus_wr_n && !bus_ale && !req_done,
            "R1 reset state", {26'd0, bus_cs_n, bus_ale, req_done}, {26'd0, 4'hF, 2'b00});
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk(bus_cs_n == 4'hF && bus_rd_n && bus_wr_n && !bus_ale,
            "R1 idle after reset", {27'd0, bus_cs_n, bus_ale}, {27'd0, 4'hF, 1'b0});

        for (int i = 0; i < 8; i++) begin
            logic [57:0] v;
            v = VEC[i];
            run(v[57], v[56:41], v[40:25], v[24:9], v[8:5], v[4], -1, int'(v[3:0]), 1'b0,
                (v[3:0] == 4'd2) ? "R3 fast region latency" : "R4 software wait latency");
        end

        // R5: ready raised after edge 5 -> done after edge 7
        run(1'b0, 16'h4ABC, 16'h0, 16'h1111, 4'b0000, 1'b0, 5, 7, 1'b0, "R5 ready stretch");
        // R4: low ready only before the software wait is not accepted
        run(1'b0, 16'h8ABC, 16'h0, 16'h2222, 4'b0000, 1'b0, 1, 4, 1'b0, "R4 ready before software wait");
        // R3: all bits set, ready held low, no stretch
        run(1'b0, 16'h8123, 16'h0, 16'h3333, 4'b1111, 1'b0, 99, 2, 1'b0, "R3 ready ignored");
        // R5 and R6: multiplexed write stretched to edge 12
        run(1'b1, 16'hD00D, 16'h5A5A, 16'h0, 4'b0111, 1'b1, 10, 12, 1'b0, "R5 long stretch");
        // R10: start pulse while busy
        run(1'b0, 16'h0F00, 16'h0, 16'h4444, 4'b1110, 1'b0, -1, 4, 1'b1, "R4 latency with busy start");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule